// File: doc/BRIEF.md
# Isochronous Endpoint Status Tracker

This block keeps the status of a single isochronous endpoint of a USB device controller. It follows the data-toggle PID in both directions and handles the extra PIDs that high-bandwidth endpoints use. It also records the length of the most recent accepted OUT packet and flags packets that are longer than the programmed endpoint size.

For an IN endpoint, the toggle field shows the PID that the next transmitted packet will carry. The field is reloaded at each microframe start from the number of transactions per microframe. It then steps down towards DATA0 as packets leave.

For an OUT endpoint, received packets fill a small ring of banks, and each bank remembers its PID. The toggle field shows the PID of the bank software is currently reading. It changes when data lands in an empty current bank, and when software releases a bank and the next one already holds data.

All fields change on the clock edge after their triggering event. Endpoint reset and endpoint disable take priority over any packet event in the same cycle.

Top module: `iso_ept_status`

## Requirements
- R1: After reset the toggle field reads DATA1 and the other fields read zero. Toggle encoding: 0 = DATA0, 1 = DATA1, 2 = DATA2, 3 = MDATA. The other fields are byte count, overflow flag, busy flag and dropped count.
- R2: IN endpoint, microframe start: a `uframe_start` pulse loads the toggle from `cfg_hb_mult`. The values 1 and 0 load DATA0, 2 loads DATA1 and 3 loads DATA2. With `HB_EN` = 0 it always loads DATA0.
- R3: IN endpoint, packet sent: each `tx_done` steps the toggle down by one value and stops at DATA0. A `uframe_start` in the same cycle wins over `tx_done`.
- R4: OUT endpoint, packet arrival: an accepted packet that lands while no bank holds data sets `sts_busy` and copies the packet PID into the toggle. A packet that lands while the current bank is already busy leaves the toggle unchanged.
- R5: OUT endpoint, bank release: a `bank_rel` while another bank holds data moves the toggle to that bank's PID. Releasing the last busy bank clears `sts_busy` and leaves the toggle unchanged.
- R6: `tgl_clr` and `ept_dis` set the toggle to DATA1 on the next edge. This overrides any packet, release or microframe event in the same cycle.
- R7: An accepted packet no longer than `cfg_max_size` sets the count to its length and clears the overflow flag and the dropped count.
- R8: An accepted packet longer than `cfg_max_size` sets the overflow flag, stops the count at `cfg_max_size` and sets the dropped count to the length minus `cfg_max_size`. All three fields change on the same edge.
- R9: `ept_rst` clears the count, the overflow flag and the dropped count, and empties all banks; it leaves the toggle unchanged. `ept_dis` does the same and also sets the toggle to DATA1. Both override a packet arriving in the same cycle.
- R10: `rx_valid` has no effect when the endpoint is configured as IN, and `tx_done` has no effect when it is configured as OUT.
- R11: A packet that arrives while all `NBANK` banks are busy is discarded. The count, overflow flag and toggle stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_hb_mult | input | 2 | Transactions per microframe (0 and 1 mean one) |
| cfg_max_size | input | LEN_W | Programmed maximum packet size in bytes |
| rx_valid | input | 1 | One-cycle pulse: a packet was received |
| rx_pid | input | 2 | PID of the received packet |
| rx_len | input | LEN_W | Length of the received packet in bytes |
| tx_done | input | 1 | One-cycle pulse: a packet was sent |
| uframe_start | input | 1 | One-cycle pulse: a new microframe began |
| tgl_clr | input | 1 | Software toggle-clear strobe |
| ept_rst | input | 1 | Endpoint reset strobe |
| ept_dis | input | 1 | Endpoint disable strobe |
| bank_rel | input | 1 | Software releases the current OUT bank |
| sts_toggle | output | 2 | Toggle PID status field |
| sts_busy | output | 1 | Current OUT bank holds received data |
| sts_count | output | LEN_W | Byte count of the last accepted packet |
| sts_ovf | output | 1 | Last accepted packet overflowed the endpoint size |
| sts_drop | output | LEN_W | Bytes beyond the endpoint size in the last packet |

## Verification
The assertions assume that `cfg_dir_in`, `cfg_hb_mult` and `cfg_max_size` are quasi-static, so they do not change in the cycle where an event is checked. They also assume that strobes are single-cycle pulses. The stimulus changes configuration only on cycles with no event and drives every strobe for exactly one cycle. It combines reset, disable and toggle-clear with packet events in the same cycle so that the priority rules are exercised. The stimulus also covers several boundary cases:
- a full bank ring;
- a packet of exactly the endpoint size;
- a zero-length packet;
- the toggle stopping at DATA0 on an IN endpoint.

// File: rtl/iso_ept_pkg.sv
package iso_ept_pkg;
   typedef logic [1:0] pid_t;
   localparam pid_t PID_DATA0 = 2'd0;
   localparam pid_t PID_DATA1 = 2'd1;
   localparam pid_t PID_DATA2 = 2'd2;
   localparam pid_t PID_MDATA = 2'd3;

   // next PID after a transmitted packet within a microframe
   function automatic pid_t pid_step_down(input pid_t cur);
      return (cur == PID_DATA0) ? PID_DATA0 : pid_t'(cur - 2'd1);
   endfunction
endpackage

// File: rtl/iso_in_seq.sv
module iso_in_seq
   import iso_ept_pkg::*;
#(
   parameter bit HB_EN = 1'b1
) (
   input  logic [1:0] hb_mult,
   input  pid_t       cur_pid,
   output pid_t       start_pid,
   output pid_t       step_pid
);
   generate
      if (HB_EN) begin : g_hb
         always_comb begin
            unique case (hb_mult)
               2'd3:    start_pid = PID_DATA2;
               2'd2:    start_pid = PID_DATA1;
               default: start_pid = PID_DATA0;
            endcase
         end
      end else begin : g_fs
         assign start_pid = PID_DATA0;
      end
   endgenerate

   assign step_pid = pid_step_down(cur_pid);
endmodule

// File: rtl/iso_out_banks.sv
module iso_out_banks
   import iso_ept_pkg::*;
#(
   parameter int NBANK = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic wr_en,
   input  pid_t wr_pid,
   input  logic rel,
   output logic accept,
   output logic busy,
   output logic head_load,
   output pid_t head_pid
);
   localparam int PTR_W  = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int FILL_W = $clog2(NBANK + 1);
   localparam logic [PTR_W-1:0]  LAST = PTR_W'(NBANK - 1);
   localparam logic [FILL_W-1:0] FULL = FILL_W'(NBANK);
   localparam logic [FILL_W-1:0] ONE  = FILL_W'(1);

   pid_t              pid_q [NBANK];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, rd_nxt, wr_nxt;
   logic [FILL_W-1:0] filled;
   logic              release_ok;

   function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   assign rd_nxt     = wrap_inc(rd_ptr);
   assign wr_nxt     = wrap_inc(wr_ptr);
   assign accept     = wr_en && (filled != FULL);
   assign release_ok = rel && (filled != '0);
   assign busy       = (filled != '0);

   assign head_load = (accept && ((filled == '0) || (release_ok && filled == ONE)))
                    || (release_ok && filled > ONE);
   assign head_pid  = (release_ok && filled > ONE) ? pid_q[rd_nxt] : wr_pid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         filled <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         filled <= '0;
      end else begin
         if (accept)     wr_ptr <= wr_nxt;
         if (release_ok) rd_ptr <= rd_nxt;
         filled <= filled + FILL_W'(accept) - FILL_W'(release_ok);
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pid_q[b] <= PID_DATA0;
         else if (!flush && accept && wr_ptr == PTR_W'(b))
            pid_q[b] <= wr_pid;
      end
   end

   assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !flush) |=> busy);
   assert_last_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rel && filled == ONE && !wr_en && !flush) |=> !busy);
   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !busy);
endmodule

// File: rtl/iso_len_check.sv
module iso_len_check #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W-1:0] max_size,
   output logic [LEN_W-1:0] cnt,
   output logic [LEN_W-1:0] drop,
   output logic             ovf
);
   logic too_long;
   assign too_long = (len > max_size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         drop <= '0;
         ovf  <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         drop <= '0;
         ovf  <= 1'b0;
      end else if (upd) begin
         ovf  <= too_long;
         cnt  <= too_long ? max_size : len;
         drop <= too_long ? (len - max_size) : '0;
      end
   end

   assert_ovf_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && len > max_size) |=> (ovf && cnt == $past(max_size)));
   assert_fit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && len <= max_size) |=> (!ovf && drop == '0 && cnt == $past(len)));
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!ovf && cnt == '0 && drop == '0));
endmodule

// File: rtl/iso_ept_status.sv
module iso_ept_status
   import iso_ept_pkg::*;
#(
   parameter int LEN_W = 11,
   parameter int NBANK = 2,
   parameter bit HB_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_dir_in,
   input  logic [1:0]       cfg_hb_mult,
   input  logic [LEN_W-1:0] cfg_max_size,
   input  logic             rx_valid,
   input  logic [1:0]       rx_pid,
   input  logic [LEN_W-1:0] rx_len,
   input  logic             tx_done,
   input  logic             uframe_start,
   input  logic             tgl_clr,
   input  logic             ept_rst,
   input  logic             ept_dis,
   input  logic             bank_rel,
   output logic [1:0]       sts_toggle,
   output logic             sts_busy,
   output logic [LEN_W-1:0] sts_count,
   output logic             sts_ovf,
   output logic [LEN_W-1:0] sts_drop
);
   generate
      if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
         $error("iso_ept_status: NBANK must be 1..4");
      end
      if (LEN_W < 4 || LEN_W > 16) begin : g_bad_len
         $error("iso_ept_status: LEN_W must be 4..16");
      end
   endgenerate

   logic flush, out_wr, out_rel, accept, head_load;
   pid_t head_pid, start_pid, step_pid, tgl_q;

   assign flush   = ept_rst | ept_dis;
   assign out_wr  = rx_valid && !cfg_dir_in && !flush;
   assign out_rel = bank_rel && !cfg_dir_in && !flush;

   iso_in_seq #(.HB_EN(HB_EN)) u_in_seq (
      .hb_mult   (cfg_hb_mult),
      .cur_pid   (tgl_q),
      .start_pid (start_pid),
      .step_pid  (step_pid)
   );

   iso_out_banks #(.NBANK(NBANK)) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (out_wr),
      .wr_pid    (rx_pid),
      .rel       (out_rel),
      .accept    (accept),
      .busy      (sts_busy),
      .head_load (head_load),
      .head_pid  (head_pid)
   );

   iso_len_check #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .upd      (accept),
      .len      (rx_len),
      .max_size (cfg_max_size),
      .cnt      (sts_count),
      .drop     (sts_drop),
      .ovf      (sts_ovf)
   );

   // toggle register: disable / clear first, then direction-specific events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tgl_q <= PID_DATA1;
      else if (ept_dis || tgl_clr)
         tgl_q <= PID_DATA1;
      else if (cfg_dir_in) begin
         if (uframe_start)  tgl_q <= start_pid;
         else if (tx_done)  tgl_q <= step_pid;
      end else if (head_load && !ept_rst)
         tgl_q <= head_pid;
   end

   assign sts_toggle = tgl_q;

   assert_clr_data1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl_clr || ept_dis) |=> sts_toggle == PID_DATA1);
   assert_in_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && tx_done && !uframe_start && !tgl_clr && !ept_dis
       && sts_toggle == PID_DATA0) |=> sts_toggle == PID_DATA0);
   assert_in_no_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && rx_valid && !flush) |=> $stable(sts_count));
   assert_rst_keeps_tgl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ept_rst && !ept_dis && !tgl_clr && !cfg_dir_in) |=> $stable(sts_toggle));
endmodule

// File: tb/iso_ept_status_test.sv
module iso_ept_status_test;
   localparam int LEN_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_dir_in = 1'b0;
   logic [1:0]       cfg_hb_mult = 2'd1;
   logic [LEN_W-1:0] cfg_max_size = 11'd64;
   logic             rx_valid = 1'b0;
   logic [1:0]       rx_pid = 2'd0;
   logic [LEN_W-1:0] rx_len = '0;
   logic             tx_done = 1'b0, uframe_start = 1'b0, tgl_clr = 1'b0;
   logic             ept_rst = 1'b0, ept_dis = 1'b0, bank_rel = 1'b0;
   logic [1:0]       sts_toggle;
   logic             sts_busy, sts_ovf;
   logic [LEN_W-1:0] sts_count, sts_drop;

   always #5 clk = ~clk;

   iso_ept_status #(.LEN_W(LEN_W), .NBANK(2), .HB_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_hb_mult(cfg_hb_mult),
      .cfg_max_size(cfg_max_size), .rx_valid(rx_valid), .rx_pid(rx_pid),
      .rx_len(rx_len), .tx_done(tx_done), .uframe_start(uframe_start),
      .tgl_clr(tgl_clr), .ept_rst(ept_rst), .ept_dis(ept_dis), .bank_rel(bank_rel),
      .sts_toggle(sts_toggle), .sts_busy(sts_busy), .sts_count(sts_count),
      .sts_ovf(sts_ovf), .sts_drop(sts_drop)
   );

   typedef struct {
      string tag;
      int    tgl;
      int    cnt;
      int    ovf;
      int    busy;
      int    drop;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int   n_checks = 0;
   int   n_errs = 0;
   bit   done = 1'b0;

   // driver: inputs are already set after a negedge; push expectation, run one edge
   task automatic go(input string tag, input int t, input int c, input int o,
                     input int b, input int d);
      exp_t x;
      x.tag = tag; x.tgl = t; x.cnt = c; x.ovf = o; x.busy = b; x.drop = d;
      q.push_back(x);
      @(negedge clk);
      rx_valid = 1'b0; tx_done = 1'b0; uframe_start = 1'b0; tgl_clr = 1'b0;
      ept_rst = 1'b0; ept_dis = 1'b0; bank_rel = 1'b0;
   endtask

   task automatic rx(input int pid, input int len);
      rx_valid = 1'b1; rx_pid = 2'(pid); rx_len = LEN_W'(len);
   endtask

   // monitor: compares after each rising edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         e = q.pop_front();
         n_checks++;
         if (int'(sts_toggle) != e.tgl || int'(sts_count) != e.cnt ||
             int'(sts_ovf) != e.ovf || int'(sts_busy) != e.busy ||
             int'(sts_drop) != e.drop) begin
            n_errs++;
            $display("FAIL %s: got tgl=%0d cnt=%0d ovf=%0d busy=%0d drop=%0d expected tgl=%0d cnt=%0d ovf=%0d busy=%0d drop=%0d",
                     e.tag, sts_toggle, sts_count, sts_ovf, sts_busy, sts_drop,
                     e.tgl, e.cnt, e.ovf, e.busy, e.drop);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_errs++;
         n_checks++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      go("R1 reset state", 1, 0, 0, 0, 0);
      // OUT endpoint, two banks, 64-byte endpoint
      rx(0, 10);                 go("R4 R7 first packet", 0, 10, 0, 1, 0);
      rx(1, 20);                 go("R4 second bank keeps toggle", 0, 20, 0, 1, 0);
      rx(2, 5);                  go("R11 full ring discards", 0, 20, 0, 1, 0);
      bank_rel = 1'b1;           go("R5 release to next bank", 1, 20, 0, 1, 0);
      bank_rel = 1'b1;           go("R5 release last bank", 1, 20, 0, 0, 0);
      rx(0, 128);                go("R8 overflow 128 on 64", 0, 64, 1, 1, 64);
      rx(3, 64);                 go("R7 exact size", 0, 64, 0, 1, 0);
      tgl_clr = 1'b1;            go("R6 toggle clear", 1, 64, 0, 1, 0);
      ept_rst = 1'b1; rx(2, 100); go("R9 reset beats packet", 1, 0, 0, 0, 0);
      rx(2, 100);                go("R8 overflow drop 36", 2, 64, 1, 1, 36);
      ept_dis = 1'b1; rx(0, 5);  go("R9 R6 disable beats packet", 1, 0, 0, 0, 0);
      tgl_clr = 1'b1; rx(0, 0);  go("R6 clear beats zero-length packet", 1, 0, 0, 1, 0);
      tx_done = 1'b1;            go("R10 tx ignored on OUT", 1, 0, 0, 1, 0);
      // IN endpoint, three transactions per microframe
      ept_rst = 1'b1;            go("R9 reset before IN", 1, 0, 0, 0, 0);
      cfg_dir_in = 1'b1; cfg_hb_mult = 2'd3;
      uframe_start = 1'b1; tx_done = 1'b1; go("R2 R3 start wins over tx", 2, 0, 0, 0, 0);
      tx_done = 1'b1;            go("R3 step to DATA1", 1, 0, 0, 0, 0);
      tx_done = 1'b1;            go("R3 step to DATA0", 0, 0, 0, 0, 0);
      tx_done = 1'b1;            go("R3 stays DATA0", 0, 0, 0, 0, 0);
      rx(0, 30);                 go("R10 rx ignored on IN", 0, 0, 0, 0, 0);
      cfg_hb_mult = 2'd2;
      uframe_start = 1'b1;       go("R2 two per microframe", 1, 0, 0, 0, 0);
      cfg_hb_mult = 2'd0;
      uframe_start = 1'b1;       go("R2 zero treated as one", 0, 0, 0, 0, 0);
      cfg_hb_mult = 2'd3;
      tgl_clr = 1'b1; uframe_start = 1'b1; go("R6 clear beats microframe start", 1, 0, 0, 0, 0);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule